// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level page table kept in memory: a directory, then a table. Directory entries can also map a 4 MB page directly. A client asks for one translation at a time and states whether the access is a write and whether it comes from user level. The walker reads the entries through a simple request/ready memory port and combines the protection bits of both levels. It writes the accessed and dirty bits back into memory where they are needed.

Each request ends in one of two ways. On success it returns the physical address together with a write-permission flag. On failure it returns a three-bit fault code, and the faulting linear address is held on a separate output. With paging switched off the block passes the address straight through and makes no memory access. The control inputs are sampled when a request is accepted, and that happens only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: With `cfg_paging` low, an accepted request completes with `res_paddr` equal to `req_lin & cfg_a20_mask`, `res_write` = 1 and `res_large` = 0, and no memory access is made.
- R2: The directory entry is read from `{cfg_base[31:12], lin[31:22], 2'b00} & cfg_a20_mask`.
- R3: For a 4 KB mapping the table entry is read from `{pde[31:12], lin[21:12], 2'b00} & cfg_a20_mask`.
- R4: An entry with bit 0 (present) clear ends the walk with `fault`. The code in `err_code` is bit 0 = 0 (not present), bit 1 = write and bit 2 = user, and `fault_lin` holds the request address.
- R5: When the directory entry has bit 7 set and `cfg_pse` is high, the walk stops at that entry. The result then has `res_large` = 1 and `res_paddr = {pde[31:22], lin[21:0]} & mask`. With `cfg_pse` low, bit 7 is ignored and a table entry is read.
- R6: For 4 KB pages, the effective user bit (bit 2) and the effective writable bit (bit 1) are each the AND of the same bit in both entries. `res_paddr = {pte[31:12], lin[11:0]} & mask`.
- R7: A user access faults when the effective user bit is 0, or when it is a write and the effective writable bit is 0. A supervisor write faults only when `cfg_wp` is high and the effective writable bit is 0. Such faults set `err_code` bit 0.
- R8: A directory entry whose bit 5 (accessed) is clear is written back with bit 5 set before the table entry is read. This applies only to 4 KB mappings.
- R9: The final entry is written back once, with bit 5 set and, on a write, bit 6 (dirty) set. This happens only if bit 5 was clear, or if the access is a write and bit 6 was clear.
- R10: `res_write` is 1 only when the final entry is dirty after the walk. User accesses also need the effective writable bit. Supervisor accesses need the writable bit or `cfg_wp` low.
- R11: Every accepted request gives exactly one single-cycle pulse on `done` or on `fault`. `req_valid` is ignored while `busy` is high. The results hold until the next request is accepted.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_lin | input | 32 | Linear address to translate |
| req_user | input | 1 | Access comes from user level |
| req_write | input | 1 | Access is a write |
| cfg_paging | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor writes honour read-only pages |
| cfg_pse | input | 1 | Large-page enable |
| cfg_base | input | 32 | Directory base (bits 31:12 used) |
| cfg_a20_mask | input | 32 | Mask applied to every physical address |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current access |
| done | output | 1 | Translation succeeded (one-cycle pulse) |
| fault | output | 1 | Page fault (one-cycle pulse) |
| res_paddr | output | 32 | Physical address |
| res_write | output | 1 | Write permission for the page |
| res_large | output | 1 | Mapping is a 4 MB page |
| err_code | output | 3 | Fault code {user, write, protection} |
| fault_lin | output | 32 | Linear address of the last request |

## Verification
A wrong walk state shows up directly at the memory port. It appears as an extra read, a missing write-back, or an entry address that does not match the formula. The bench counts reads and writes and logs their addresses, so it catches such errors within the same request. A wrong permission combination shows up at the ends of the walk. It either flips `done` into `fault`, or it corrupts `err_code` or `res_write` in the very cycle the request ends. Lost or repeated completion pulses are counted in a short window after each request.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_lin,
  input  logic        req_user,
  input  logic        req_write,
  input  logic        cfg_paging,
  input  logic        cfg_wp,
  input  logic        cfg_pse,
  input  logic [31:0] cfg_base,
  input  logic [31:0] cfg_a20_mask,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        done,
  output logic        fault,
  output logic [31:0] res_paddr,
  output logic        res_write,
  output logic        res_large,
  output logic [2:0]  err_code,
  output logic [31:0] fault_lin
);
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WR_DIR, S_RD_TBL, S_WR_FIN, S_DONE, S_FAULT
  } st_t;

  st_t         st;
  logic [31:0] lin_r, a20_r, dir_r, fin_r;
  logic [19:0] base_r;
  logic        usr_r, wr_r, pg_r, wp_r, pse_r, large_r, eu_r, ew_r, prot_r;

  logic [31:0] dir_addr, tbl_addr, fin_addr;
  logic        big, tbl_eu, tbl_ew;

  assign dir_addr = {base_r, lin_r[31:22], 2'b00} & a20_r;
  assign tbl_addr = {dir_r[31:12], lin_r[21:12], 2'b00} & a20_r;
  assign fin_addr = large_r ? dir_addr : tbl_addr;
  assign big      = mem_rdata[B_PS] & pse_r;
  assign tbl_eu   = mem_rdata[B_US] & dir_r[B_US];
  assign tbl_ew   = mem_rdata[B_RW] & dir_r[B_RW];

  function automatic logic violates(input logic u, input logic w, input logic wp,
                                    input logic eu, input logic ew);
    return u ? (!eu || (w && !ew)) : (wp && w && !ew);
  endfunction

  function automatic logic needs_upd(input logic [31:0] e, input logic w);
    return !e[B_A] || (w && !e[B_D]);
  endfunction

  assign busy      = st != S_IDLE;
  assign mem_req   = st inside {S_RD_DIR, S_WR_DIR, S_RD_TBL, S_WR_FIN};
  assign mem_we    = st inside {S_WR_DIR, S_WR_FIN};
  assign mem_addr  = (st == S_RD_DIR || st == S_WR_DIR) ? dir_addr :
                     (st == S_RD_TBL) ? tbl_addr : fin_addr;
  assign mem_wdata = (st == S_WR_DIR) ? (dir_r | (32'd1 << B_A)) :
                     (fin_r | (32'd1 << B_A) | ({31'd0, wr_r} << B_D));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lin_r <= '0; a20_r <= '0; dir_r <= '0; fin_r <= '0; base_r <= '0;
      usr_r <= 1'b0; wr_r <= 1'b0; pg_r <= 1'b0; wp_r <= 1'b0; pse_r <= 1'b0;
      large_r <= 1'b0; eu_r <= 1'b0; ew_r <= 1'b0; prot_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_r <= req_lin; usr_r <= req_user; wr_r <= req_write;
          pg_r <= cfg_paging; wp_r <= cfg_wp; pse_r <= cfg_pse;
          base_r <= cfg_base[31:12]; a20_r <= cfg_a20_mask;
          large_r <= 1'b0; prot_r <= 1'b0;
          st <= cfg_paging ? S_RD_DIR : S_DONE;
        end
        S_RD_DIR: if (mem_ready) begin
          dir_r <= mem_rdata;
          if (!mem_rdata[B_P]) st <= S_FAULT;
          else if (big) begin
            large_r <= 1'b1; fin_r <= mem_rdata;
            eu_r <= mem_rdata[B_US]; ew_r <= mem_rdata[B_RW];
            if (violates(usr_r, wr_r, wp_r, mem_rdata[B_US], mem_rdata[B_RW])) begin
              prot_r <= 1'b1; st <= S_FAULT;
            end else st <= needs_upd(mem_rdata, wr_r) ? S_WR_FIN : S_DONE;
          end else st <= mem_rdata[B_A] ? S_RD_TBL : S_WR_DIR;
        end
        S_WR_DIR: if (mem_ready) st <= S_RD_TBL;
        S_RD_TBL: if (mem_ready) begin
          fin_r <= mem_rdata; eu_r <= tbl_eu; ew_r <= tbl_ew;
          if (!mem_rdata[B_P]) st <= S_FAULT;
          else if (violates(usr_r, wr_r, wp_r, tbl_eu, tbl_ew)) begin
            prot_r <= 1'b1; st <= S_FAULT;
          end else st <= needs_upd(mem_rdata, wr_r) ? S_WR_FIN : S_DONE;
        end
        S_WR_FIN: if (mem_ready) st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign done      = st == S_DONE;
  assign fault     = st == S_FAULT;
  assign err_code  = {usr_r, wr_r, prot_r};
  assign fault_lin = lin_r;
  assign res_large = pg_r & large_r;
  assign res_paddr = (!pg_r   ? lin_r :
                      large_r ? {fin_r[31:22], lin_r[21:0]} :
                                {fin_r[31:12], lin_r[11:0]}) & a20_r;
  assign res_write = !pg_r ||
                     ((fin_r[B_D] || wr_r) && (usr_r ? ew_r : (ew_r || !wp_r)));
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        done,
  input logic        fault,
  input logic [31:0] res_paddr,
  input logic [2:0]  err_code,
  input logic [31:0] fault_lin
);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  assert_results_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> ($stable(fault_lin) && $stable(res_paddr) && $stable(err_code)));

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_wb_accessed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && mem_wdata[5]));

  assert_no_mem_when_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !mem_req);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
  logic [31:0] req_lin = '0;
  logic        cfg_paging = 1'b1, cfg_wp = 1'b0, cfg_pse = 1'b0;
  logic [31:0] cfg_base = 32'h0010_0000, cfg_a20_mask = 32'hFFFF_FFFF;
  logic        busy, mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        done, fault, res_write, res_large;
  logic [31:0] res_paddr, fault_lin;
  logic [2:0]  err_code;

  always #5 clk = ~clk;

  pt_walker u0 (.*);

  logic [31:0] mem [logic [31:0]];
  int          lat = 0, wcnt = 0, nrd = 0, nwr = 0;
  logic [31:0] rda [4];
  logic [31:0] last_wa = '0, last_wd = '0;
  int          checks = 0, errors = 0;

  always @(negedge clk) begin
    if (!rst_n) begin mem_ready = 1'b0; wcnt = 0; end
    else if (mem_ready) begin mem_ready = 1'b0; wcnt = 0; end
    else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata; nwr++; last_wa = mem_addr; last_wd = mem_wdata;
        end else begin
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          if (nrd < 4) rda[nrd] = mem_addr;
          nrd++;
        end
      end else wcnt++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] lin, input logic u, input logic w, output int pulses);
    int cyc;
    nrd = 0; nwr = 0; last_wa = '0; last_wd = '0;
    @(negedge clk);
    req_lin = lin; req_user = u; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!(done || fault) && cyc < 500) begin @(negedge clk); cyc++; end
    pulses = (done || fault) ? 1 : 0;
    chk(cyc < 500, "R11 completion", cyc, 500);
    repeat (4) begin @(negedge clk); if (done || fault) pulses++; end
  endtask

  typedef struct packed {
    logic [31:0] lin;
    logic        usr, wr, pse, wp;
    logic [31:0] pde, pte;
    logic        xf;
    logic [2:0]  xerr;
    logic [31:0] xpa;
    logic        xw;
    logic [3:0]  xrd, xwr;
    logic [31:0] xwd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R6 plain user read, dirty page
    '{32'h0040_1234, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0020_0027, 32'h0030_0067, 1'b0, 3'd0, 32'h0030_0234, 1'b1, 4'd2, 4'd0, 32'h0},
    // R8 R9 both accessed bits clear, user write
    '{32'h0040_1234, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0020_0007, 32'h0030_0007, 1'b0, 3'd0, 32'h0030_0234, 1'b1, 4'd2, 4'd2, 32'h0030_0067},
    // R7 user write to read-only table entry
    '{32'h0040_1234, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0020_0027, 32'h0030_0025, 1'b1, 3'd7, 32'h0,         1'b0, 4'd2, 4'd0, 32'h0},
    // R7 user read of supervisor page
    '{32'h0040_1234, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0020_0027, 32'h0030_0063, 1'b1, 3'd5, 32'h0,         1'b0, 4'd2, 4'd0, 32'h0},
    // R6 R10 supervisor write, directory read-only, wp clear
    '{32'h0040_1234, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0020_0025, 32'h0030_0067, 1'b0, 3'd0, 32'h0030_0234, 1'b1, 4'd2, 4'd0, 32'h0},
    // R7 same with wp set
    '{32'h0040_1234, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0020_0025, 32'h0030_0067, 1'b1, 3'd3, 32'h0,         1'b0, 4'd2, 4'd0, 32'h0},
    // R4 directory not present
    '{32'h0040_1234, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0020_0026, 32'h0030_0067, 1'b1, 3'd6, 32'h0,         1'b0, 4'd1, 4'd0, 32'h0},
    // R4 table not present, supervisor read
    '{32'h0040_1234, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0020_0027, 32'h0030_0066, 1'b1, 3'd0, 32'h0,         1'b0, 4'd2, 4'd0, 32'h0},
    // R5 large page, supervisor read of clean page
    '{32'h0040_1234, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0080_00A7, 32'h0030_0067, 1'b0, 3'd0, 32'h0080_1234, 1'b0, 4'd1, 4'd0, 32'h0},
    // R5 size bit ignored with large pages disabled
    '{32'h0040_1234, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0080_00A7, 32'h0030_0067, 1'b0, 3'd0, 32'h0030_0234, 1'b1, 4'd2, 4'd0, 32'h0},
    // R10 clean page read gives no write permission
    '{32'h0040_1234, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0020_0027, 32'h0030_0027, 1'b0, 3'd0, 32'h0030_0234, 1'b0, 4'd2, 4'd0, 32'h0},
    // R9 supervisor write sets dirty only
    '{32'h0040_1234, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0020_0027, 32'h0030_0027, 1'b0, 3'd0, 32'h0030_0234, 1'b1, 4'd2, 4'd1, 32'h0030_0067},
    // R5 R9 large page user write, one write-back to directory entry
    '{32'h0040_1234, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0080_0087, 32'h0030_0067, 1'b0, 3'd0, 32'h0080_1234, 1'b1, 4'd1, 4'd1, 32'h0080_00E7}
  };

  initial begin
    int pulses;
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    chk(!done && !fault && !busy && !mem_req, "R11 reset state",
        {28'd0, done, fault, busy, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] pde_a, pte_a, fin_a;
      logic        lg;
      vec_t v;
      v = VECS[i];
      mem.delete();
      lat = i % 3;
      pde_a = cfg_base + {20'd0, v.lin[31:22], 2'b00};
      pte_a = (v.pde & 32'hFFFF_F000) + {20'd0, v.lin[21:12], 2'b00};
      lg = v.pse && v.pde[7];
      fin_a = lg ? pde_a : pte_a;
      mem[pde_a] = v.pde;
      mem[pte_a] = v.pte;
      cfg_pse = v.pse; cfg_wp = v.wp; cfg_paging = 1'b1;
      run(v.lin, v.usr, v.wr, pulses);
      chk(pulses == 1, "R11 pulse count", pulses, 1);
      chk(fault == 1'b0 && done == 1'b0, "R11 pulse ended", {fault, done}, 0);
      chk(nrd == v.xrd, "R5 R8 read count", nrd, v.xrd);
      chk(nwr == v.xwr, "R8 R9 write count", nwr, v.xwr);
      chk(rda[0] == pde_a, "R2 directory address", rda[0], pde_a);
      if (v.xrd == 2) chk(rda[1] == pte_a, "R3 table address", rda[1], pte_a);
      if (v.xwr != 0) begin
        chk(last_wd == v.xwd, "R9 write-back data", last_wd, v.xwd);
        chk(last_wa == fin_a, "R9 write-back address", last_wa, fin_a);
      end
      if (v.xf) begin
        chk(err_code == v.xerr, "R4 R7 fault code", err_code, v.xerr);
        chk(fault_lin == v.lin, "R4 fault address", fault_lin, v.lin);
      end else begin
        chk(res_paddr == v.xpa, "R5 R6 physical address", res_paddr, v.xpa);
        chk(res_write == v.xw, "R10 write permission", res_write, v.xw);
        chk(res_large == lg, "R5 large flag", res_large, lg);
      end
    end

    // R1: paging off, A20 masked, no memory traffic
    mem.delete();
    lat = 0;
    cfg_paging = 1'b0; cfg_a20_mask = 32'hFFEF_FFFF;
    run(32'h1234_5678, 1'b1, 1'b1, pulses);
    chk(pulses == 1 && done == 1'b0, "R1 pulse", pulses, 1);
    chk(res_paddr == 32'h1224_5678, "R1 identity address", res_paddr, 32'h1224_5678);
    chk(res_write == 1'b1 && res_large == 1'b0, "R1 permissions", {res_write, res_large}, 2'b10);
    chk(nrd == 0 && nwr == 0, "R1 no memory access", nrd + nwr, 0);

    // R2: mask clears bit 20 of the directory base
    mem.delete();
    cfg_paging = 1'b1; cfg_pse = 1'b0; cfg_wp = 1'b0;
    mem[32'h0000_0004] = 32'h0020_0027;
    mem[32'h0020_0004] = 32'h0030_0067;
    run(32'h0040_1234, 1'b0, 1'b0, pulses);
    chk(rda[0] == 32'h0000_0004, "R2 masked directory address", rda[0], 32'h0000_0004);
    chk(res_paddr == 32'h0020_0234, "R2 masked result", res_paddr, 32'h0020_0234);
    cfg_a20_mask = 32'hFFFF_FFFF;

    // R11 R12: slow memory, second request while busy is ignored
    mem.delete();
    lat = 3;
    mem[32'h0010_0004] = 32'h0020_0027;
    mem[32'h0020_0004] = 32'h0030_0067;
    mem[32'h0010_0FFC] = 32'h0000_0000;
    nrd = 0; nwr = 0;
    begin
      int cyc, pc;
      @(negedge clk);
      req_lin = 32'h0040_1234; req_user = 1'b0; req_write = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R11 busy during walk", busy, 1);
      req_lin = 32'hFFC0_0000; req_user = 1'b1; req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0; pc = 0;
      while (cyc < 60) begin
        @(negedge clk);
        if (done || fault) pc++;
        if (done) chk(res_paddr == 32'h0030_0234, "R11 first request served", res_paddr, 32'h0030_0234);
        cyc++;
      end
      chk(pc == 1, "R11 single pulse", pc, 1);
      chk(fault_lin == 32'h0040_1234, "R11 busy request ignored", fault_lin, 32'h0040_1234);
      chk(nrd == 2 && nwr == 0, "R12 reads under latency", nrd, 2);
      chk(err_code == 3'd0, "R11 code of first request", err_code, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule